// File: doc/BRIEF.md
# Bidirectional Common Scan Driver

This block drives the common (row) side of a dot matrix liquid crystal panel. A chain of 64 one-bit stages carries a single active token from one end of the row bank to the other, one stage per active edge of a shift clock. Each stage feeds a level selector. The selector combines the stage bit with the frame alternation input and produces a two-bit code. The code names one of four drive voltages that the analog switches downstream must connect to the row.

The two end pins are serial data ports. The direction input decides which end accepts the token and which end passes it on. This lets a second identical driver take over the scan for panels with up to 128 rows. Another input picks whether the chain moves on the rising or the falling edge of the shift clock. The shift clock is sampled by the block's system clock, so edges are found as changes between consecutive samples. Each bidirectional pin is modelled as an input, an output and an output enable.

Top module: `com_scan_driver`

## Requirements
- R1: With `dir_fwd`=1 the token enters at `left_in`, moves toward output 64 and leaves on `right_out`, with `right_oe`=1 and `left_oe`=0. With `dir_fwd`=0 it enters at `right_in`, moves toward output 1 and leaves on `left_out`, with `left_oe`=1 and `right_oe`=0. An output pin whose enable is low reads 0.
- R2: Stage 1 is the stage next to the left pin and drives `lvl_code[1:0]`. Stage k drives `lvl_code[2k-1:2k-2]`, and stage 64 drives `lvl_code[127:126]`.
- R3: With `edge_rise`=1 the chain moves only when `shift_clk` rises. With `edge_rise`=0 it moves only when `shift_clk` falls. The inactive edge leaves every stage and both serial outputs unchanged.
- R4: The level code is `{~bit, alt_m}`. This gives 00 for the selected level with alt_m=0, 01 for the selected level with alt_m=1, 10 for the idle level with alt_m=0, and 11 for the idle level with alt_m=1.
- R5: In forward scan the first token injected shows on output 1, which is row 1. In reverse scan it shows on output 64, which then serves as row 1.
- R6: A token injected on the input end reaches the output pin on the 64th active edge and not before.
- R7: Reset clears all stages. Every output then shows its idle code, and both serial outputs read 0.
- R8: Serial data changes only on an active edge, and the input pin is sampled on that same edge. The clock edge and the data are seen in the same system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the shift clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_clk | input | 1 | Scan shift clock |
| edge_rise | input | 1 | 1: move on rising edge, 0: on falling edge |
| dir_fwd | input | 1 | 1: left to right, 0: right to left |
| alt_m | input | 1 | Frame alternation phase |
| left_in | input | 1 | Left end pin, input side |
| right_in | input | 1 | Right end pin, input side |
| left_out | output | 1 | Left end pin, output side |
| left_oe | output | 1 | Left end pin drive enable |
| right_out | output | 1 | Right end pin, output side |
| right_oe | output | 1 | Right end pin drive enable |
| lvl_code | output | 128 | Two-bit drive level code per row output |

## Verification
A table of steps changes direction, edge polarity, alternation phase and input data from step to step. It compares the full 64-row code vector after both the active and the inactive clock edge. Comparing after the inactive edge separates a correct edge choice from a chain that moves on both edges. Reversing direction in mid-stream shows whether the entry end and the enables really swap. Alternating `alt_m` with the data exposes swapped level encodings. Single-token walks in each direction count exactly 64 active edges before the token leaves, which catches an off-by-one chain or a mirrored output order. A reset in the middle of a scan checks that the idle codes return.

// File: rtl/com_scan_pkg.sv
package com_scan_pkg;
  localparam int unsigned ROWS_DFLT = 64;
  localparam int unsigned CODE_W    = 2;

  // code = {idle, alternation phase}
  typedef enum logic [CODE_W-1:0] {
    LVL_SEL_PH0  = 2'b00,
    LVL_SEL_PH1  = 2'b01,
    LVL_IDLE_PH0 = 2'b10,
    LVL_IDLE_PH1 = 2'b11
  } drive_lvl_t;

  function automatic drive_lvl_t pick_level(input logic active, input logic phase);
    drive_lvl_t r;
    if (active) r = phase ? LVL_SEL_PH1 : LVL_SEL_PH0;
    else        r = phase ? LVL_IDLE_PH1 : LVL_IDLE_PH0;
    return r;
  endfunction
endpackage

// File: rtl/com_edge_pick.sv
module com_edge_pick (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic rise_sel,
  output logic shift_en
);
  logic sclk_q;
  logic rose_w;
  logic fell_w;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rose_w   = sclk & ~sclk_q;
  assign fell_w   = ~sclk & sclk_q;
  assign shift_en = rise_sel ? rose_w : fell_w;

  AST_EDGE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (sclk == rise_sel)); // R3
endmodule

// File: rtl/com_shift_chain.sv
module com_shift_chain #(
  parameter int unsigned ROWS = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            fwd,
  input  logic            left_in,
  input  logic            right_in,
  output logic [ROWS-1:0] stg
);
  localparam int unsigned LAST = ROWS - 1;

  logic [ROWS-1:0] nxt;

  generate
    for (genvar i = 0; i < ROWS; i++) begin : g_stage
      logic from_left;
      logic from_right;
      if (i == 0) begin : g_lend
        assign from_left = left_in;
      end else begin : g_lmid
        assign from_left = stg[i-1];
      end
      if (i == LAST) begin : g_rend
        assign from_right = right_in;
      end else begin : g_rmid
        assign from_right = stg[i+1];
      end
      assign nxt[i] = fwd ? from_left : from_right;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        stg <= '0;
    else if (shift_en) stg <= nxt;
  end

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stg)); // R3
endmodule

// File: rtl/com_level_map.sv
module com_level_map
  import com_scan_pkg::*;
#(
  parameter int unsigned ROWS = 64
) (
  input  logic                   phase,
  input  logic [ROWS-1:0]        stg,
  output logic [ROWS*CODE_W-1:0] codes
);
  generate
    for (genvar i = 0; i < ROWS; i++) begin : g_lvl
      drive_lvl_t l;
      assign l = pick_level(stg[i], phase);
      assign codes[i*CODE_W +: CODE_W] = l;
    end
  endgenerate
endmodule

// File: rtl/com_scan_driver.sv
module com_scan_driver
  import com_scan_pkg::*;
#(
  parameter int unsigned ROWS = ROWS_DFLT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_clk,
  input  logic                   edge_rise,
  input  logic                   dir_fwd,
  input  logic                   alt_m,
  input  logic                   left_in,
  input  logic                   right_in,
  output logic                   left_out,
  output logic                   left_oe,
  output logic                   right_out,
  output logic                   right_oe,
  output logic [ROWS*CODE_W-1:0] lvl_code
);
  localparam int unsigned LAST = ROWS - 1;

  logic            shift_en;
  logic [ROWS-1:0] stg;

  com_edge_pick u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (shift_clk),
    .rise_sel (edge_rise),
    .shift_en (shift_en)
  );

  com_shift_chain #(.ROWS(ROWS)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .fwd      (dir_fwd),
    .left_in  (left_in),
    .right_in (right_in),
    .stg      (stg)
  );

  com_level_map #(.ROWS(ROWS)) u_map (
    .phase (alt_m),
    .stg   (stg),
    .codes (lvl_code)
  );

  assign right_oe  = dir_fwd;
  assign left_oe   = ~dir_fwd;
  assign right_out = dir_fwd  & stg[LAST];
  assign left_out  = ~dir_fwd & stg[0];

  AST_FWD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && dir_fwd) |=> (stg[0] == $past(left_in))); // R1
  AST_REV_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !dir_fwd) |=> (stg[LAST] == $past(right_in))); // R1
  AST_CASCADE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && dir_fwd && $past(dir_fwd) && dir_fwd == 1'b1) |=> (right_out == $past(stg[LAST-1]))); // R6
  AST_LEVEL_ROW1: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_code[1:0] == 2'b00) |-> (stg[0] && !alt_m)); // R4
endmodule

// File: tb/tb_com_scan_driver.sv
module tb_com_scan_driver;
  localparam int ROWS = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_clk = 1'b0, edge_rise = 1'b1, dir_fwd = 1'b1, alt_m = 1'b0;
  logic left_in = 1'b0, right_in = 1'b0;
  logic left_out, left_oe, right_out, right_oe;
  logic [2*ROWS-1:0] lvl_code;

  int total = 0;
  int bad = 0;
  logic [ROWS-1:0] mdl = '0;

  always #4 clk = ~clk;

  com_scan_driver #(.ROWS(ROWS)) dut (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .edge_rise(edge_rise),
    .dir_fwd(dir_fwd), .alt_m(alt_m), .left_in(left_in), .right_in(right_in),
    .left_out(left_out), .left_oe(left_oe), .right_out(right_out),
    .right_oe(right_oe), .lvl_code(lvl_code)
  );

  // fields: {dir_fwd, edge_rise, alt_m, data_in}
  localparam logic [3:0] VEC [12] = '{
    4'b1101, 4'b1110, 4'b1101, 4'b1011, 4'b1000, 4'b0110,
    4'b0101, 4'b0010, 4'b0001, 4'b1111, 4'b0000, 4'b1010
  };

  function automatic logic [1:0] exp_code(input logic b, input logic m);
    return {!b, m};
  endfunction

  task automatic check_all(input string req);
    logic [2*ROWS-1:0] e;
    logic eo_r, eo_l;
    for (int i = 0; i < ROWS; i++) e[2*i +: 2] = exp_code(mdl[i], alt_m);
    eo_r = dir_fwd ? mdl[ROWS-1] : 1'b0;
    eo_l = dir_fwd ? 1'b0 : mdl[0];
    total++;
    if (lvl_code !== e) begin
      bad++;
      $display("FAIL %s codes act=%h exp=%h", req, lvl_code, e);
    end
    total++;
    if ({right_out, left_out, right_oe, left_oe} !== {eo_r, eo_l, dir_fwd, !dir_fwd}) begin
      bad++;
      $display("FAIL %s pins act=%b exp=%b", req,
               {right_out, left_out, right_oe, left_oe}, {eo_r, eo_l, dir_fwd, !dir_fwd});
    end
  endtask

  task automatic model_shift(input logic din);
    if (dir_fwd) mdl = {mdl[ROWS-2:0], din};
    else         mdl = {din, mdl[ROWS-1:1]};
  endtask

  // one phase of the shift clock; sampled one full cycle later (R8)
  task automatic phase(input logic v, input logic din);
    @(negedge clk) shift_clk = v;
    @(negedge clk);
    if (v == edge_rise) model_shift(din);
  endtask

  task automatic step(input logic din, input string req);
    if (dir_fwd) left_in = din; else right_in = din;
    phase(1'b1, din);
    check_all(req);
    phase(1'b0, din);
    check_all(req);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    shift_clk = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mdl = '0;
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    check_all("R7 reset idle");

    // table walk: R1 R2 R3 R4 R8
    foreach (VEC[k]) begin
      dir_fwd = VEC[k][3];
      edge_rise = VEC[k][2];
      alt_m = VEC[k][1];
      step(VEC[k][0], "R3 R4 table");
    end

    // R7: reset in mid scan returns idle codes, alt_m=1
    alt_m = 1'b1;
    do_reset();
    check_all("R7 mid reset");

    // R5 R6 forward walk: token on output 1 first, exits on 64th edge
    dir_fwd = 1'b1; edge_rise = 1'b1; alt_m = 1'b0;
    step(1'b1, "R5 fwd row1");
    total++;
    if (lvl_code[1:0] !== 2'b00) begin
      bad++; $display("FAIL R5 out1 act=%b exp=00", lvl_code[1:0]);
    end
    for (int s = 2; s <= ROWS; s++) begin
      step(1'b0, "R6 fwd walk");
      if (s == ROWS-1) begin
        total++;
        if (right_out !== 1'b0) begin bad++; $display("FAIL R6 early act=%b exp=0", right_out); end
      end
    end
    total++;
    if (right_out !== 1'b1) begin bad++; $display("FAIL R6 fwd exit act=%b exp=1", right_out); end

    // R5 R6 reverse walk, falling edge
    do_reset();
    dir_fwd = 1'b0; edge_rise = 1'b0; alt_m = 1'b1;
    step(1'b1, "R5 rev row1");
    total++;
    if (lvl_code[2*ROWS-1 -: 2] !== 2'b01) begin
      bad++; $display("FAIL R5 out64 act=%b exp=01", lvl_code[2*ROWS-1 -: 2]);
    end
    for (int s = 2; s <= ROWS; s++) step(1'b0, "R6 rev walk");
    total++;
    if (left_out !== 1'b1) begin bad++; $display("FAIL R6 rev exit act=%b exp=1", left_out); end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule